// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block predicts return targets for a fetch pipeline. Each call pushes its return address, and each return pops the predicted target. The fast level is a shallow stack that answers in the same cycle. Behind it sits a deeper, slower backing store.

When a call arrives with the fast level full, the fast level's bottom entry is moved into the backing store. When a return takes the last fast entry while the backing store still holds addresses, the newest backing entry is brought forward. Each of these transfers holds `busy_o` high for a fixed number of cycles, which models the slow access. While `busy_o` is high the caller stalls, and call and return strobes are ignored.

For recovery, the fetch unit takes a checkpoint of the depth pointers. A later flush restores that checkpoint in a single cycle.

Top module: `ras2l`

## Requirements
- R1: After reset, `pred_valid_o` is 0 and `busy_o` is 0.
- R2: A call while not busy, with fewer than FAST_N (4) fast entries, costs no busy cycles. On the next cycle the output shows `pred_valid_o`=1 and `pred_addr_o` equal to the pushed address.
- R3: Returns present the stored addresses in last-in, first-out order. The output shows the current top, and a return removes it.
- R4: A call while the fast level is full moves the bottom fast entry into the backing store. `busy_o` is then 1 for exactly SLOW_CYC (7) cycles, and `pred_valid_o` is 0 while `busy_o` is 1. Afterwards the new address is on top.
- R5: A return that empties the fast level while the backing store is non-empty moves the newest backing entry to the fast level. This costs SLOW_CYC (7) busy cycles, and that entry is the next prediction. A spill followed by a refill therefore costs 14 cycles.
- R6: A return with both levels empty leaves `pred_valid_o` at 0 and does not raise `busy_o`.
- R7: The combined capacity is FAST_N+SLOW_N (36). Pushing more than that overwrites the oldest backing entries. Those returns are lost, and the newest 36 still pop in order.
- R8: A call and a return in the same cycle replace the top entry without changing the depth. On an empty stack the pair acts as a push.
- R9: `ckpt_i` saves both levels' depth pointers. `flush_i` restores them on the next edge and clears `busy_o`. Flush takes priority over calls and returns.
- R10: Call and return strobes are ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe (push) |
| ret_i | input | 1 | Return strobe (pop) |
| call_addr_i | input | AW | Return address to push |
| ckpt_i | input | 1 | Save depth pointers |
| flush_i | input | 1 | Restore saved depth pointers |
| pred_valid_o | output | 1 | Predicted target is valid |
| pred_addr_o | output | AW | Predicted return target |
| busy_o | output | 1 | Backing-store transfer in progress; caller stalls |

## Verification
The main function is exercised with four kinds of input pattern.

- **Shallow call/return nesting within the fast level.** This separates plain LIFO behaviour from spill and refill traffic.
- **A single overflow followed by unwinding to empty.** This shows the exact busy length of a spill and of a refill, and that the refilled address is the right one.
- **A nest deeper than the total capacity.** This distinguishes correct wraparound from corruption of the newest entries.
- **Paired call-and-return strobes, strobes issued while busy, and flushes after a checkpoint.** These separate top replacement, ignored input and pointer restore from ordinary pushes and pops.

// File: rtl/ras2l.sv
`timescale 1ns/1ps
module ras2l #(
  parameter int AW       = 32,
  parameter int FAST_N   = 4,
  parameter int SLOW_N   = 32,
  parameter int SLOW_CYC = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] call_addr_i,
  input  logic          ckpt_i,
  input  logic          flush_i,
  output logic          pred_valid_o,
  output logic [AW-1:0] pred_addr_o,
  output logic          busy_o
);
  localparam int FW  = $clog2(FAST_N + 1);
  localparam int FIW = (FAST_N > 1) ? $clog2(FAST_N) : 1;
  localparam int SPW = (SLOW_N > 1) ? $clog2(SLOW_N) : 1;
  localparam int SCW = $clog2(SLOW_N + 1);
  localparam int BW  = $clog2(SLOW_CYC + 1);

  logic [AW-1:0]  fast_q [FAST_N];
  logic [AW-1:0]  slow_q [SLOW_N];
  logic [FW-1:0]  fcnt_q, fcnt_ck;
  logic [SPW-1:0] swp_q, swp_ck;
  logic [SCW-1:0] scnt_q, scnt_ck;
  logic [BW-1:0]  bcnt_q;

  wire act       = (bcnt_q == '0) && !flush_i;
  wire do_push   = act && call_i && !ret_i;
  wire do_pop    = act && ret_i && !call_i && (fcnt_q != '0);
  wire do_swap   = act && call_i && ret_i;
  wire fast_full = (fcnt_q == FW'(FAST_N));
  wire spill     = do_push && fast_full;
  wire refill    = do_pop && (fcnt_q == FW'(1)) && (scnt_q != '0);

  wire [FIW-1:0] ftop  = FIW'(fcnt_q - 1'b1);
  wire [FIW-1:0] fnext = FIW'(fcnt_q);
  wire [SPW-1:0] swp_inc = (swp_q == SPW'(SLOW_N - 1)) ? '0 : swp_q + 1'b1;
  wire [SPW-1:0] swp_dec = (swp_q == '0) ? SPW'(SLOW_N - 1) : swp_q - 1'b1;

  assign busy_o       = (bcnt_q != '0);
  assign pred_valid_o = (fcnt_q != '0) && !busy_o;
  assign pred_addr_o  = pred_valid_o ? fast_q[ftop] : '0;

  always_ff @(posedge clk) begin
    if (spill) begin
      for (int i = 0; i < FAST_N - 1; i++) fast_q[i] <= fast_q[i+1];
      fast_q[FAST_N-1] <= call_addr_i;
      slow_q[swp_q]    <= fast_q[0];
    end else if (do_push) begin
      fast_q[fnext] <= call_addr_i;
    end else if (do_swap) begin
      fast_q[(fcnt_q == '0) ? '0 : ftop] <= call_addr_i;
    end else if (refill) begin
      fast_q[0] <= slow_q[swp_dec];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt_ck <= '0;
      swp_ck  <= '0;
      scnt_ck <= '0;
    end else if (ckpt_i) begin
      fcnt_ck <= fcnt_q;
      swp_ck  <= swp_q;
      scnt_ck <= scnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      swp_q  <= '0;
      scnt_q <= '0;
      bcnt_q <= '0;
    end else if (flush_i) begin
      fcnt_q <= fcnt_ck;
      swp_q  <= swp_ck;
      scnt_q <= scnt_ck;
      bcnt_q <= '0;
    end else begin
      if (busy_o) bcnt_q <= bcnt_q - 1'b1;
      if (spill) begin
        swp_q  <= swp_inc;
        if (scnt_q != SCW'(SLOW_N)) scnt_q <= scnt_q + 1'b1;
        bcnt_q <= BW'(SLOW_CYC);
      end else if (do_push) begin
        fcnt_q <= fcnt_q + 1'b1;
      end else if (do_swap && fcnt_q == '0) begin
        fcnt_q <= FW'(1);
      end else if (refill) begin
        swp_q  <= swp_dec;
        scnt_q <= scnt_q - 1'b1;
        bcnt_q <= BW'(SLOW_CYC);
      end else if (do_pop) begin
        fcnt_q <= fcnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ras2l_chk.sv
`timescale 1ns/1ps
module ras2l_chk #(
  parameter int AW       = 32,
  parameter int FAST_N   = 4,
  parameter int SLOW_N   = 32,
  parameter int SLOW_CYC = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic          ret_i,
  input logic [AW-1:0] call_addr_i,
  input logic          flush_i,
  input logic          pred_valid_o,
  input logic [AW-1:0] pred_addr_o,
  input logic          busy_o,
  input logic [$clog2(FAST_N+1)-1:0] fcnt_q,
  input logic [$clog2(SLOW_N+1)-1:0] scnt_q
);
  localparam int FW = $clog2(FAST_N + 1);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy_o ? run_q + 1 : '0;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy_o && !pred_valid_o);

  a_r2_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && !ret_i && !busy_o && !flush_i && fcnt_q < FW'(FAST_N)
    |=> pred_valid_o && pred_addr_o == $past(call_addr_i) && !busy_o);

  a_r4_spill_busy: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && !ret_i && !busy_o && !flush_i && fcnt_q == FW'(FAST_N) |=> busy_o);

  a_r4_no_pred_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pred_valid_o);

  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) && !$past(flush_i) |-> run_q == SLOW_CYC);

  a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !call_i && !busy_o && !flush_i && fcnt_q == '0
    |=> !busy_o && fcnt_q == '0 && $stable(scnt_q));

  a_r8_swap_top: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && ret_i && !busy_o && !flush_i && fcnt_q != '0
    |=> pred_valid_o && pred_addr_o == $past(call_addr_i) && $stable(fcnt_q));

  a_r9_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !busy_o);

  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !flush_i |=> $stable(fcnt_q) && $stable(scnt_q));
endmodule

bind ras2l ras2l_chk #(.AW(AW), .FAST_N(FAST_N), .SLOW_N(SLOW_N), .SLOW_CYC(SLOW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .call_addr_i(call_addr_i),
  .flush_i(flush_i), .pred_valid_o(pred_valid_o), .pred_addr_o(pred_addr_o),
  .busy_o(busy_o), .fcnt_q(fcnt_q), .scnt_q(scnt_q)
);

// File: tb/ras2l_tb.sv
`timescale 1ns/1ps
module ras2l_tb;
  localparam int AW = 32;
  localparam int SLOW_CYC = 7;

  logic clk = 1'b0;
  logic rst_n, call_i, ret_i, ckpt_i, flush_i;
  logic [AW-1:0] call_addr_i;
  logic pred_valid_o, busy_o;
  logic [AW-1:0] pred_addr_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ras2l u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .call_addr_i(call_addr_i),
    .ckpt_i(ckpt_i), .flush_i(flush_i), .pred_valid_o(pred_valid_o),
    .pred_addr_o(pred_addr_o), .busy_o(busy_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [7:0]  bz;
    logic        ev;
    logic [31:0] ea;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{2'd1, 32'h101, 8'd0, 1'b1, 32'h101, 8'd2},  // R2
    '{2'd1, 32'h102, 8'd0, 1'b1, 32'h102, 8'd2},
    '{2'd1, 32'h103, 8'd0, 1'b1, 32'h103, 8'd2},
    '{2'd1, 32'h104, 8'd0, 1'b1, 32'h104, 8'd2},
    '{2'd1, 32'h105, 8'd7, 1'b1, 32'h105, 8'd4},  // R4 spill
    '{2'd2, 32'h0,   8'd0, 1'b1, 32'h104, 8'd3},  // R3
    '{2'd2, 32'h0,   8'd0, 1'b1, 32'h103, 8'd3},
    '{2'd2, 32'h0,   8'd0, 1'b1, 32'h102, 8'd3},
    '{2'd2, 32'h0,   8'd7, 1'b1, 32'h101, 8'd5},  // R5 refill
    '{2'd2, 32'h0,   8'd0, 1'b0, 32'h0,   8'd3},
    '{2'd2, 32'h0,   8'd0, 1'b0, 32'h0,   8'd6},  // R6 empty pop
    '{2'd3, 32'h200, 8'd0, 1'b1, 32'h200, 8'd8},  // R8 pair on empty
    '{2'd3, 32'h201, 8'd0, 1'b1, 32'h201, 8'd8},  // R8 replace
    '{2'd2, 32'h0,   8'd0, 1'b0, 32'h0,   8'd8}   // R8 depth unchanged
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; call_i = 0; ret_i = 0; ckpt_i = 0; flush_i = 0; call_addr_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] a, output int n);
    call_i = op[0]; ret_i = op[1]; call_addr_i = a;
    @(negedge clk);
    call_i = 0; ret_i = 0;
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  task automatic pulse(input bit ck, input bit fl);
    ckpt_i = ck; flush_i = fl;
    @(negedge clk);
    ckpt_i = 0; flush_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    chk("R1 valid", 32'(pred_valid_o), 0);
    chk("R1 busy", 32'(busy_o), 0);

    for (int i = 0; i < 14; i++) begin
      do_op(VEC[i].op, VEC[i].addr, n);
      chk($sformatf("vec%0d R%0d busy", i, VEC[i].req), n, 32'(VEC[i].bz));
      chk($sformatf("vec%0d R%0d valid", i, VEC[i].req), 32'(pred_valid_o), 32'(VEC[i].ev));
      if (VEC[i].ev) chk($sformatf("vec%0d R%0d addr", i, VEC[i].req), pred_addr_o, VEC[i].ea);
    end

    // R7: wraparound beyond 36 entries
    do_reset();
    for (int k = 0; k < 38; k++) do_op(2'd1, 32'h1000 + k, n);
    for (int k = 37; k >= 2; k--) begin
      chk("R7 valid", 32'(pred_valid_o), 1);
      chk("R7 addr", pred_addr_o, 32'h1000 + k);
      do_op(2'd2, 32'h0, n);
    end
    chk("R7 oldest lost", 32'(pred_valid_o), 0);

    // R10: strobes while busy are ignored
    do_reset();
    for (int k = 1; k <= 5; k++) begin
      call_i = 1; call_addr_i = 32'h300 + k;
      @(negedge clk);
      call_i = 0;
    end
    chk("R10 busy", 32'(busy_o), 1);
    call_i = 1; call_addr_i = 32'hDEAD; @(negedge clk); call_i = 0;
    ret_i = 1; @(negedge clk); ret_i = 0;
    while (busy_o) @(negedge clk);
    chk("R10 top kept", pred_addr_o, 32'h305);
    do_op(2'd2, 32'h0, n);
    chk("R10 next kept", pred_addr_o, 32'h304);

    // R9: checkpoint and flush
    do_reset();
    do_op(2'd1, 32'hA0, n);
    do_op(2'd1, 32'hB0, n);
    pulse(1, 0);
    do_op(2'd1, 32'hC0, n);
    for (int k = 0; k < 3; k++) do_op(2'd2, 32'h0, n);
    chk("R9 emptied", 32'(pred_valid_o), 0);
    pulse(0, 1);
    chk("R9 restored valid", 32'(pred_valid_o), 1);
    chk("R9 restored addr", pred_addr_o, 32'hB0);
    do_op(2'd2, 32'h0, n);
    chk("R9 below", pred_addr_o, 32'hA0);

    // R9: flush cancels a busy window
    do_reset();
    for (int k = 0; k < 4; k++) do_op(2'd1, 32'h400 + k, n);
    pulse(1, 0);
    call_i = 1; call_addr_i = 32'h404; @(negedge clk); call_i = 0;
    chk("R9 spill busy", 32'(busy_o), 1);
    pulse(0, 1);
    chk("R9 flush clears busy", 32'(busy_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule